// File: doc/BRIEF.md
# Command/Response FIFO Engine

This block is the command engine behind one locality of a memory-mapped host interface to a security coprocessor. The host loads a command byte by byte through a data FIFO register and starts it with a go strobe in the status register. It then reads the response back through the same FIFO register. One byte buffer holds the command first and the response afterwards. The engine moves through five states: idle, ready, reception, execution and completion. It finds the command length in the command header while bytes are still arriving, and the expect flag follows from that length.

Status reads return the flags and a burst count. The coprocessor side uses a request/complete handshake. The coprocessor reads the command from the buffer and writes the response into it through its own port. For an abort it gets a cancel pulse. Bus decoding, interrupts and locality arbitration belong to the surrounding logic.

Top module: `cre_fifo_engine`

## Requirements
- R1: After reset the engine is idle. All flags read 0 and the burst count equals DEPTH. A FIFO read returns 0x000000FF, and neither coprocessor strobe is asserted.
- R2: A status write acts only when the written byte, masked to bits 6 (command-ready), 5 (go) and 1 (retry), equals exactly one of those bits. Command-ready behaves per state:
  - In idle it sets command-ready and enters ready.
  - In ready it only clears the offset.
  - In reception it aborts at once: the state becomes ready, command-ready is the only flag and the offset is 0.
  - In completion it enters ready with command-ready as the only flag, data-available clear and the offset 0.
- R3: Command-ready during execution pulses the cancel output for one cycle and leaves the status unchanged. The next coprocessor completion then lands in ready with command-ready as the only flag and the offset at 0.
- R4: FIFO writes are dropped in idle, execution and completion. The first FIFO write in ready enters reception and sets valid and expect.
- R5: The command length is a 32-bit big-endian field in buffer bytes 2 to 5. Expect stays set through the first 6 bytes. After that it is set only while the length exceeds the received count, and once it clears, further FIFO bytes are not stored.
- R6: Go takes effect only in reception with expect clear. It pulses the request output for one cycle, with the length output set to the received byte count. In any other case it has no effect.
- R7: Coprocessor completion sets the flags to valid plus data-available, enters completion and clears the offset. Self-test-done, reported with completion, stays set until reset.
- R8: The response length is the smaller of the buffer header length and DEPTH.
  - In completion with data-available set, each FIFO read returns the buffer byte at the offset and advances the offset.
  - Reading the last response byte leaves only valid set.
  - At any other time a FIFO read returns 0xFF.
- R9: Retry in completion clears the offset and sets valid plus data-available again. In any other state it is ignored.
- R10: A status read returns the following fields:
  - bits 27:26 hold the FAMILY parameter and bits 23:8 the burst count;
  - the flag bits are valid (bit 7), command-ready (bit 6), data-available (bit 4), expect (bit 3) and self-test-done (bit 2).
  
  The burst count is the number of response bytes left when data-available is set. Otherwise it is DEPTH minus the offset, clamped to 255 on a byte-sized read.
- R11: A FIFO byte arriving with the buffer full is not stored, and the flags fall back to valid alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_fifo_i | input | 1 | 1 selects the data FIFO, 0 the status register |
| host_byte_i | input | 1 | Byte-sized status read |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 32 | Host read data for the current access |
| cop_req_o | output | 1 | Command request pulse |
| cop_len_o | output | OFF_W | Command length of the last request |
| cop_cancel_o | output | 1 | Cancel pulse |
| cop_done_i | input | 1 | Response complete |
| cop_selftest_i | input | 1 | Self-test done, sampled with cop_done_i |
| cop_we_i | input | 1 | Coprocessor buffer write |
| cop_addr_i | input | OFF_W | Coprocessor buffer address |
| cop_wdata_i | input | 8 | Coprocessor write byte |
| cop_rdata_o | output | 8 | Buffer byte at cop_addr_i |

## Verification
The bench builds the engine with DEPTH = 300 and FAMILY = 2. At that depth a 300-byte command fills the buffer, so the overflow fallback and a response header larger than the buffer can be reached in a few hundred cycles. The free-space count still exceeds 255, which exercises the byte-read clamp. Random command lengths include values below 6, so the rule that holds expect through the header is also covered.

// File: rtl/cre_pkg.sv
package cre_pkg;
  typedef enum logic [2:0] {
    CRE_IDLE  = 3'd0,
    CRE_READY = 3'd1,
    CRE_CMPL  = 3'd2,
    CRE_EXEC  = 3'd3,
    CRE_RECV  = 3'd4
  } cre_state_e;

  typedef struct packed {
    logic valid;
    logic cmd_ready;
    logic data_avail;
    logic exp_more;
  } cre_flags_t;

  localparam int unsigned CR_BIT    = 6;
  localparam int unsigned GO_BIT    = 5;
  localparam int unsigned RETRY_BIT = 1;
  localparam int unsigned BURST_W   = 16;
  localparam int unsigned HDR_FIRST = 2;
  localparam int unsigned HDR_BYTES = 4;

  function automatic cre_flags_t cre_mk(logic v, logic cr, logic da, logic em);
    return '{valid: v, cmd_ready: cr, data_avail: da, exp_more: em};
  endfunction
endpackage

// File: rtl/cre_buffer.sv
module cre_buffer #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned OFF_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_we_i,
  input  logic [OFF_W-1:0] host_addr_i,
  input  logic [7:0]       host_wdata_i,
  output logic [7:0]       host_rdata_o,
  input  logic             cop_we_i,
  input  logic [OFF_W-1:0] cop_addr_i,
  input  logic [7:0]       cop_wdata_i,
  output logic [7:0]       cop_rdata_o,
  output logic [31:0]      hdr_len_o
);
  import cre_pkg::*;
  localparam int unsigned AW = $clog2(DEPTH);

  logic [7:0] mem_q [DEPTH];
  logic host_ok, cop_ok;
  logic [HDR_BYTES-1:0][7:0] hdr_b;

  assign host_ok = host_addr_i < OFF_W'(DEPTH);
  assign cop_ok  = cop_addr_i < OFF_W'(DEPTH);

  always_ff @(posedge clk_i) begin
    if (host_we_i && host_ok)    mem_q[host_addr_i[AW-1:0]] <= host_wdata_i;
    else if (cop_we_i && cop_ok) mem_q[cop_addr_i[AW-1:0]]  <= cop_wdata_i;
  end

  assign host_rdata_o = host_ok ? mem_q[host_addr_i[AW-1:0]] : 8'hFF;
  assign cop_rdata_o  = cop_ok  ? mem_q[cop_addr_i[AW-1:0]]  : 8'hFF;

  // shadow of the big-endian length field, fed by either writer
  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr
    localparam logic [OFF_W-1:0] POS = OFF_W'(HDR_FIRST + g);
    logic [7:0] b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              b_q <= '0;
      else if (host_we_i && host_addr_i == POS) b_q <= host_wdata_i;
      else if (cop_we_i && cop_addr_i == POS)   b_q <= cop_wdata_i;
    end
    assign hdr_b[g] = b_q;
  end

  assign hdr_len_o = {hdr_b[0], hdr_b[1], hdr_b[2], hdr_b[3]};
endmodule

// File: rtl/cre_ctrl.sv
module cre_ctrl #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned OFF_W = 13
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                host_wr_i,
  input  logic                host_rd_i,
  input  logic                host_fifo_i,
  input  logic [7:0]          host_wdata_i,
  input  logic                cop_done_i,
  input  logic                cop_selftest_i,
  input  logic [31:0]         hdr_len_i,
  output cre_pkg::cre_state_e state_o,
  output cre_pkg::cre_flags_t flags_o,
  output logic                selftest_o,
  output logic [OFF_W-1:0]    off_o,
  output logic [OFF_W-1:0]    rsp_len_o,
  output logic                buf_we_o,
  output logic                cop_req_o,
  output logic                cop_cancel_o,
  output logic [OFF_W-1:0]    cop_len_o
);
  import cre_pkg::*;
  localparam logic [7:0] STS_MASK = 8'((1 << CR_BIT) | (1 << GO_BIT) | (1 << RETRY_BIT));
  localparam logic [7:0] CODE_CR  = 8'(1 << CR_BIT);
  localparam logic [7:0] CODE_GO  = 8'(1 << GO_BIT);
  localparam logic [7:0] CODE_RT  = 8'(1 << RETRY_BIT);

  cre_state_e state_q, state_d;
  cre_flags_t flags_q, flags_d, f;
  logic [OFF_W-1:0] off_q, off_d, off_n, len_q, len_d;
  logic selftest_q, selftest_d, abort_q, abort_d;
  logic req_q, req_d, cancel_q, cancel_d;
  logic [7:0] code;
  logic [31:0] hdr_now;

  assign code      = host_wdata_i & STS_MASK;
  assign off_n     = off_q + 1'b1;
  assign rsp_len_o = (hdr_len_i > 32'(DEPTH)) ? OFF_W'(DEPTH) : hdr_len_i[OFF_W-1:0];

  // length field including the byte being written this cycle
  always_comb begin
    hdr_now = hdr_len_i;
    if (off_q == OFF_W'(2)) hdr_now[31:24] = host_wdata_i;
    if (off_q == OFF_W'(3)) hdr_now[23:16] = host_wdata_i;
    if (off_q == OFF_W'(4)) hdr_now[15:8]  = host_wdata_i;
    if (off_q == OFF_W'(5)) hdr_now[7:0]   = host_wdata_i;
  end

  always_comb begin
    state_d    = state_q;
    flags_d    = flags_q;
    off_d      = off_q;
    selftest_d = selftest_q;
    abort_d    = abort_q;
    len_d      = len_q;
    req_d      = 1'b0;
    cancel_d   = 1'b0;
    buf_we_o   = 1'b0;
    f          = flags_q;
    if (state_q == CRE_EXEC && cop_done_i) begin
      if (cop_selftest_i) selftest_d = 1'b1;
      off_d = '0;
      if (abort_q) begin
        state_d = CRE_READY;
        flags_d = cre_mk(1'b0, 1'b1, 1'b0, 1'b0);
        abort_d = 1'b0;
      end else begin
        state_d = CRE_CMPL;
        flags_d = cre_mk(1'b1, 1'b0, 1'b1, 1'b0);
      end
    end else if (host_wr_i && !host_fifo_i) begin
      if (code == CODE_CR) begin
        unique case (state_q)
          CRE_IDLE: begin
            state_d = CRE_READY;
            flags_d = cre_mk(1'b0, 1'b1, 1'b0, 1'b0);
          end
          CRE_READY: off_d = '0;
          CRE_RECV: begin
            off_d   = '0;
            state_d = CRE_READY;
            flags_d = cre_mk(1'b0, 1'b1, 1'b0, 1'b0);
          end
          CRE_EXEC: begin
            cancel_d = !abort_q;
            abort_d  = 1'b1;
          end
          CRE_CMPL: begin
            off_d   = '0;
            state_d = CRE_READY;
            if (!flags_q.cmd_ready) f = cre_mk(1'b0, 1'b1, 1'b0, 1'b0);
            f.data_avail = 1'b0;
            flags_d = f;
          end
          default: ;
        endcase
      end else if (code == CODE_GO) begin
        if (state_q == CRE_RECV && !flags_q.exp_more) begin
          state_d = CRE_EXEC;
          req_d   = 1'b1;
          len_d   = off_q;
        end
      end else if (code == CODE_RT) begin
        if (state_q == CRE_CMPL) begin
          off_d   = '0;
          flags_d = cre_mk(1'b1, 1'b0, 1'b1, 1'b0);
        end
      end
    end else if (host_wr_i && host_fifo_i) begin
      if (state_q == CRE_READY || state_q == CRE_RECV) begin
        if (state_q == CRE_READY) begin
          state_d = CRE_RECV;
          f = cre_mk(1'b1, 1'b0, 1'b0, 1'b1);
        end
        if (f.exp_more) begin
          if (off_q < OFF_W'(DEPTH)) begin
            buf_we_o = 1'b1;
            off_d    = off_n;
            if (off_n > OFF_W'(5))
              f = cre_mk(1'b1, 1'b0, 1'b0, hdr_now > 32'(off_n));
          end else begin
            f = cre_mk(1'b1, 1'b0, 1'b0, 1'b0);
          end
        end
        flags_d = f;
      end
    end else if (host_rd_i && host_fifo_i && state_q == CRE_CMPL && flags_q.data_avail) begin
      off_d = off_n;
      if (off_n >= rsp_len_o) flags_d = cre_mk(1'b1, 1'b0, 1'b0, 1'b0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= CRE_IDLE;
      flags_q    <= '0;
      off_q      <= '0;
      selftest_q <= 1'b0;
      abort_q    <= 1'b0;
      len_q      <= '0;
      req_q      <= 1'b0;
      cancel_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      flags_q    <= flags_d;
      off_q      <= off_d;
      selftest_q <= selftest_d;
      abort_q    <= abort_d;
      len_q      <= len_d;
      req_q      <= req_d;
      cancel_q   <= cancel_d;
    end
  end

  assign state_o      = state_q;
  assign flags_o      = flags_q;
  assign selftest_o   = selftest_q;
  assign off_o        = off_q;
  assign cop_req_o    = req_q;
  assign cop_cancel_o = cancel_q;
  assign cop_len_o    = len_q;

  a_r11_offset_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q <= OFF_W'(DEPTH));
  a_r5_expect_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flags_q.exp_more && flags_q.data_avail));
  a_r8_avail_in_cmpl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q.data_avail |-> state_q == CRE_CMPL);
  a_r7_selftest_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    selftest_q |=> selftest_q);
  a_r7_done_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CRE_EXEC && cop_done_i) |=>
      (off_q == '0 && (state_q == CRE_CMPL || state_q == CRE_READY)));
  a_r4_drop_keeps_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_fifo_i && !cop_done_i &&
     (state_q == CRE_IDLE || state_q == CRE_EXEC || state_q == CRE_CMPL)) |=> $stable(off_q));
  a_r3_cancel_in_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_cancel_o |-> (state_q == CRE_EXEC && abort_q));
  a_r6_req_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_req_o |-> (state_q == CRE_EXEC && cop_len_o == off_q));
endmodule

// File: rtl/cre_status.sv
module cre_status #(
  parameter int unsigned DEPTH  = 4096,
  parameter int unsigned OFF_W  = 13,
  parameter logic [1:0]  FAMILY = 2'b01
) (
  input  cre_pkg::cre_state_e state_i,
  input  cre_pkg::cre_flags_t flags_i,
  input  logic                selftest_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic [OFF_W-1:0]    rsp_len_i,
  input  logic                byte_i,
  input  logic                fifo_i,
  input  logic [7:0]          buf_byte_i,
  output logic [31:0]         rdata_o
);
  import cre_pkg::*;
  logic [BURST_W-1:0] burst;
  logic [7:0] fifo_byte;

  always_comb begin
    if (flags_i.data_avail) begin
      burst = (rsp_len_i > off_i) ? BURST_W'(rsp_len_i - off_i) : '0;
    end else begin
      burst = BURST_W'(OFF_W'(DEPTH) - off_i);
      if (byte_i && burst > BURST_W'(255)) burst = BURST_W'(255);
    end
  end

  assign fifo_byte = (state_i == CRE_CMPL && flags_i.data_avail) ? buf_byte_i : 8'hFF;

  assign rdata_o = fifo_i ? {24'h0, fifo_byte}
                          : {4'h0, FAMILY, 2'b00, burst,
                             flags_i.valid, flags_i.cmd_ready, 1'b0, flags_i.data_avail,
                             flags_i.exp_more, selftest_i, 2'b00};
endmodule

// File: rtl/cre_fifo_engine.sv
module cre_fifo_engine #(
  parameter int unsigned DEPTH  = 4096,
  parameter logic [1:0]  FAMILY = 2'b01,
  localparam int unsigned OFF_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_wr_i,
  input  logic             host_rd_i,
  input  logic             host_fifo_i,
  input  logic             host_byte_i,
  input  logic [7:0]       host_wdata_i,
  output logic [31:0]      host_rdata_o,
  output logic             cop_req_o,
  output logic [OFF_W-1:0] cop_len_o,
  output logic             cop_cancel_o,
  input  logic             cop_done_i,
  input  logic             cop_selftest_i,
  input  logic             cop_we_i,
  input  logic [OFF_W-1:0] cop_addr_i,
  input  logic [7:0]       cop_wdata_i,
  output logic [7:0]       cop_rdata_o
);
  import cre_pkg::*;

  cre_state_e       state;
  cre_flags_t       flags;
  logic             selftest, buf_we;
  logic [OFF_W-1:0] off, rsp_len;
  logic [7:0]       buf_byte;
  logic [31:0]      hdr_len;

  cre_ctrl #(.DEPTH(DEPTH), .OFF_W(OFF_W)) i_ctrl (
    .clk_i, .rst_ni, .host_wr_i, .host_rd_i, .host_fifo_i, .host_wdata_i,
    .cop_done_i, .cop_selftest_i, .hdr_len_i(hdr_len),
    .state_o(state), .flags_o(flags), .selftest_o(selftest), .off_o(off),
    .rsp_len_o(rsp_len), .buf_we_o(buf_we),
    .cop_req_o, .cop_cancel_o, .cop_len_o
  );

  cre_buffer #(.DEPTH(DEPTH), .OFF_W(OFF_W)) i_buffer (
    .clk_i, .rst_ni,
    .host_we_i(buf_we), .host_addr_i(off), .host_wdata_i, .host_rdata_o(buf_byte),
    .cop_we_i, .cop_addr_i, .cop_wdata_i, .cop_rdata_o,
    .hdr_len_o(hdr_len)
  );

  cre_status #(.DEPTH(DEPTH), .OFF_W(OFF_W), .FAMILY(FAMILY)) i_status (
    .state_i(state), .flags_i(flags), .selftest_i(selftest), .off_i(off),
    .rsp_len_i(rsp_len), .byte_i(host_byte_i), .fifo_i(host_fifo_i),
    .buf_byte_i(buf_byte), .rdata_o(host_rdata_o)
  );
endmodule

// File: tb/test_cre_fifo_engine.sv
module test_cre_fifo_engine;
  localparam int unsigned DEPTH = 300;
  localparam logic [1:0]  FAM   = 2'b10;
  localparam int unsigned OFF_W = $clog2(DEPTH + 1);
  localparam logic [7:0] C_CR = 8'h40, C_GO = 8'h20, C_RT = 8'h02;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0, host_fifo = 0, host_byte = 0;
  logic [7:0] host_wdata = 0;
  logic [31:0] host_rdata;
  logic cop_req, cop_cancel, cop_done = 0, cop_st = 0, cop_we = 0;
  logic [OFF_W-1:0] cop_len, cop_addr = '0;
  logic [7:0] cop_wdata = 0, cop_rdata;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;
  bit model_st = 0;
  logic [7:0] cmd_b [0:511];
  logic [7:0] rsp_b [0:511];

  always #5 clk = ~clk;

  cre_fifo_engine #(.DEPTH(DEPTH), .FAMILY(FAM)) i_cre_fifo_engine (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i(host_wr), .host_rd_i(host_rd),
    .host_fifo_i(host_fifo), .host_byte_i(host_byte), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata), .cop_req_o(cop_req), .cop_len_o(cop_len),
    .cop_cancel_o(cop_cancel), .cop_done_i(cop_done), .cop_selftest_i(cop_st),
    .cop_we_i(cop_we), .cop_addr_i(cop_addr), .cop_wdata_i(cop_wdata),
    .cop_rdata_o(cop_rdata)
  );

  function automatic logic [31:0] sts_exp(bit v, bit cr, bit da, bit em, bit st, int burst);
    return {4'h0, FAM, 2'b00, 16'(burst), v, cr, 1'b0, da, em, st, 2'b00};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input logic wr, input logic rd, input logic fifo, input logic bsel,
                    input logic [7:0] wd, output logic [31:0] val);
    @(negedge clk);
    host_wr = wr; host_rd = rd; host_fifo = fifo; host_byte = bsel; host_wdata = wd;
    #1 val = host_rdata;
    @(posedge clk); #1;
    host_wr = 0; host_rd = 0; host_byte = 0;
  endtask

  task automatic fifo_wr(input logic [7:0] b);
    logic [31:0] v; op(1, 0, 1, 0, b, v);
  endtask
  task automatic sts_wr(input logic [7:0] c);
    logic [31:0] v; op(1, 0, 0, 0, c, v);
  endtask
  task automatic fifo_rd(output logic [31:0] v);
    op(0, 1, 1, 0, 8'h00, v);
  endtask
  task automatic sts_rd(input logic bsel, output logic [31:0] v);
    op(0, 1, 0, bsel, 8'h00, v);
  endtask

  task automatic cop_write(input int m);
    for (int i = 0; i < m; i++) begin
      @(negedge clk); cop_we = 1; cop_addr = OFF_W'(i); cop_wdata = rsp_b[i];
      @(posedge clk); #1 cop_we = 0;
    end
  endtask

  task automatic cop_finish(input bit st);
    @(negedge clk); cop_done = 1; cop_st = st;
    @(posedge clk); #1 cop_done = 0; cop_st = 0;
  endtask

  task automatic fill_rsp(input int hdr, input int m);
    for (int i = 0; i < m; i++) rsp_b[i] = 8'($urandom_range(0, 255));
    rsp_b[2] = hdr[31:24]; rsp_b[3] = hdr[23:16]; rsp_b[4] = hdr[15:8]; rsp_b[5] = hdr[7:0];
  endtask

  task automatic run_cmd(input int len, input int m, input bit mid_retry, input bit st);
    logic [31:0] v;
    int w;
    w = (len < 6) ? 6 : len;
    for (int i = 0; i < w; i++) cmd_b[i] = 8'($urandom_range(0, 255));
    cmd_b[2] = len[31:24]; cmd_b[3] = len[23:16]; cmd_b[4] = len[15:8]; cmd_b[5] = len[7:0];
    for (int k = 1; k <= w; k++) begin
      fifo_wr(cmd_b[k-1]);
      sts_rd(0, v);
      chk(v, sts_exp(1, 0, 0, (k <= 5) ? 1'b1 : (len > k), model_st, DEPTH - k), "R5 expect tracking");
      if (k == 3) begin
        sts_wr(C_GO);
        chk({31'b0, cop_req}, 32'd0, "R6 go with expect set ignored");
        sts_rd(0, v);
        chk(v, sts_exp(1, 0, 0, 1, model_st, DEPTH - 3), "R6 go with expect set keeps status");
      end
    end
    fifo_wr(8'hA5);
    sts_rd(0, v);
    chk(v, sts_exp(1, 0, 0, 0, model_st, DEPTH - w), "R5 byte after complete not stored");
    sts_wr(C_GO);
    chk({31'b0, cop_req}, 32'd1, "R6 request pulse");
    chk(32'(cop_len), 32'(w), "R6 request length");
    sts_rd(0, v);
    chk({31'b0, cop_req}, 32'd0, "R6 request single cycle");
    chk(v, sts_exp(1, 0, 0, 0, model_st, DEPTH - w), "R6 status in execution");
    fifo_wr(8'h11);
    sts_rd(0, v);
    chk(v, sts_exp(1, 0, 0, 0, model_st, DEPTH - w), "R4 write dropped in execution");
    fifo_rd(v);
    chk(v, 32'h0000_00FF, "R8 read in execution");
    for (int i = 0; i < w; i++) begin
      @(negedge clk); cop_addr = OFF_W'(i);
      #1 chk({24'h0, cop_rdata}, {24'h0, cmd_b[i]}, "R5 command byte stored");
    end
    fill_rsp(m, m);
    cop_write(m);
    cop_finish(st);
    model_st = model_st | st;
    sts_rd(0, v);
    chk(v, sts_exp(1, 0, 1, 0, model_st, m), "R7 completion status");
    fifo_wr(8'h22);
    sts_rd(0, v);
    chk(v, sts_exp(1, 0, 1, 0, model_st, m), "R4 write dropped in completion");
    sts_wr(C_CR | C_GO);
    sts_rd(0, v);
    chk(v, sts_exp(1, 0, 1, 0, model_st, m), "R2 two codes at once ignored");
    if (mid_retry) begin
      for (int i = 0; i < m / 2; i++) begin
        fifo_rd(v);
        chk(v, {24'h0, rsp_b[i]}, "R8 response byte before retry");
      end
      sts_wr(C_RT);
      sts_rd(0, v);
      chk(v, sts_exp(1, 0, 1, 0, model_st, m), "R9 retry mid response");
    end
    for (int i = 0; i < m; i++) begin
      fifo_rd(v);
      chk(v, {24'h0, rsp_b[i]}, "R8 response byte");
    end
    sts_rd(0, v);
    chk(v, sts_exp(1, 0, 0, 0, model_st, DEPTH - m), "R8 last byte leaves valid only");
    fifo_rd(v);
    chk(v, 32'h0000_00FF, "R8 read after end");
    sts_wr(C_RT);
    sts_rd(0, v);
    chk(v, sts_exp(1, 0, 1, 0, model_st, m), "R9 retry after full read");
    fifo_rd(v);
    chk(v, {24'h0, rsp_b[0]}, "R9 retry restarts at byte 0");
    sts_wr(C_CR);
    sts_rd(0, v);
    chk(v, sts_exp(0, 1, 0, 0, model_st, DEPTH), "R2 command-ready in completion");
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    sts_rd(0, v);
    chk(v, sts_exp(0, 0, 0, 0, 0, DEPTH), "R1 status after reset");
    chk({30'b0, cop_req, cop_cancel}, 32'd0, "R1 strobes idle");
    fifo_rd(v);
    chk(v, 32'h0000_00FF, "R1 fifo read after reset");
    fifo_wr(8'h5A);
    sts_rd(0, v);
    chk(v, sts_exp(0, 0, 0, 0, 0, DEPTH), "R4 write dropped in idle");
    sts_wr(C_RT);
    sts_rd(0, v);
    chk(v, sts_exp(0, 0, 0, 0, 0, DEPTH), "R9 retry in idle ignored");
    sts_wr(C_CR);
    sts_rd(0, v);
    chk(v, sts_exp(0, 1, 0, 0, 0, DEPTH), "R2 command-ready in idle");
    sts_wr(C_CR);
    sts_rd(0, v);
    chk(v, sts_exp(0, 1, 0, 0, 0, DEPTH), "R2 command-ready in ready");
    sts_rd(1, v);
    chk(v, sts_exp(0, 1, 0, 0, 0, 255), "R10 byte read clamp");
    sts_wr(C_GO);
    chk({31'b0, cop_req}, 32'd0, "R6 go in ready ignored");
    sts_wr(C_RT);
    sts_rd(0, v);
    chk(v, sts_exp(0, 1, 0, 0, 0, DEPTH), "R9 retry in ready ignored");
    // R2 abort during reception
    fifo_wr(8'h01); fifo_wr(8'h02); fifo_wr(8'h03);
    sts_rd(0, v);
    chk(v, sts_exp(1, 0, 0, 1, 0, DEPTH - 3), "R4 first write enters reception");
    sts_wr(C_CR);
    sts_rd(0, v);
    chk(v, sts_exp(0, 1, 0, 0, 0, DEPTH), "R2 abort in reception");
    // directed and random transactions
    run_cmd(10, 12, 1, 0);
    run_cmd(2, 6, 0, 1);
    for (int t = 0; t < 14; t++)
      run_cmd($urandom_range(0, 40), $urandom_range(6, 60), $urandom_range(0, 1) == 1,
              $urandom_range(0, 5) == 0);
    // R3 abort during execution
    for (int i = 0; i < 6; i++) fifo_wr((i == 5) ? 8'd6 : 8'd0);
    sts_wr(C_GO);
    sts_wr(C_CR);
    chk({31'b0, cop_cancel}, 32'd1, "R3 cancel pulse");
    sts_rd(0, v);
    chk({31'b0, cop_cancel}, 32'd0, "R3 cancel single cycle");
    chk(v, sts_exp(1, 0, 0, 0, model_st, DEPTH - 6), "R3 status held while cancelling");
    fill_rsp(8, 8);
    cop_write(8);
    cop_finish(0);
    sts_rd(0, v);
    chk(v, sts_exp(0, 1, 0, 0, model_st, DEPTH), "R3 completion after abort lands in ready");
    fifo_rd(v);
    chk(v, 32'h0000_00FF, "R3 no response readable after abort");
    // R11 overflow with oversized header
    for (int i = 0; i < DEPTH; i++)
      fifo_wr((i == 3) ? 8'h03 : ((i == 4) ? 8'hE8 : 8'h00));
    sts_rd(0, v);
    chk(v, sts_exp(1, 0, 0, 1, model_st, 0), "R11 full buffer still expecting");
    fifo_wr(8'h77);
    sts_rd(0, v);
    chk(v, sts_exp(1, 0, 0, 0, model_st, 0), "R11 overflow falls back to valid");
    sts_wr(C_GO);
    chk(32'(cop_len), 32'(DEPTH), "R11 request length of full buffer");
    fill_rsp(1000, DEPTH);
    cop_write(DEPTH);
    cop_finish(0);
    sts_rd(0, v);
    chk(v, sts_exp(1, 0, 1, 0, model_st, DEPTH), "R8 response length clipped to depth");
    for (int i = 0; i < DEPTH; i++) begin
      fifo_rd(v);
      if (i < 8 || i >= DEPTH - 2) chk(v, {24'h0, rsp_b[i]}, "R8 long response byte");
    end
    sts_rd(0, v);
    chk(v, sts_exp(1, 0, 0, 0, model_st, 0), "R8 long response drained");
    sts_wr(C_CR);
    sts_rd(0, v);
    chk(v, sts_exp(0, 1, 0, 0, model_st, DEPTH), "R10 free space after return to ready");
    finish_up();
  end
endmodule